// File: doc/BRIEF.md
# Tree Router Output Allocator

This block holds the output-grant control of a packet router placed in a tree-shaped on-chip network. Three kinds of source compete for outputs. The shared down-going buffers come first, then the inputs that arrive from the level above, then the inputs that arrive from the level below. The targets are the down-going outputs, the up-going outputs and the shared buffers. Header decoding happens outside this block. Once a header is decoded, the source raises a request toward every target able to carry the packet. Each idle target then picks one requester and keeps that connection until the owning source signals that its trailer flit is passing.

All targets settle their choices together in one combinational pass, so a request that several targets could serve is granted exactly once. The pass visits targets in a fixed order. Down outputs go first, then up outputs starting from a rotating position, then shared buffers. A source taken by an earlier target is therefore invisible to later ones. This order gives real outputs precedence over shared buffers, and it makes competing up outputs take turns. Connections appear one clock after the requests are presented.

Top module: `tree_out_alloc`

## Requirements
- R1: Source s requests target t on bit s*NTGT+t of `req_i`. Sources are numbered with shared buffers first (0..1), then upper inputs (2..5), then lower inputs (6..9). Targets are numbered with down outputs first (0..3), then up outputs (4..7), then shared buffers (8..9).
- R2: An idle target with at least one eligible requester shows `conn_valid_o` high and the chosen source on `conn_src_o` after the next rising clock edge.
- R3: A source owns at most one target at any time. While it owns one, all of its requests are ignored.
- R4: A target prefers shared-buffer sources over upper inputs, and upper inputs over lower inputs.
- R5: Within one class, a target serves requesters round-robin. Its pointer moves past a source only when that source is granted.
- R6: When a down or up output and a shared buffer could both take the same source in one cycle, the output gets it.
- R7: Up outputs competing for one source take turns. The search starts one place after the up output that last granted.
- R8: A connection stays in place, with the same source, until `trailer_i` of its owner is high at a clock edge. At that edge the target goes idle. A trailer from a source that owns nothing has no effect.
- R9: After reset, every target is idle, every round-robin pointer starts at the first member of its class, and the up-output rotation starts at up output 0.
- R10: No request is left waiting. If a free source requests an idle target, then after the next edge either that target is busy or that source owns some target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC*NTGT | Request matrix, bit s*NTGT+t |
| trailer_i | input | NSRC | Trailer flit of each source passes this cycle |
| conn_valid_o | output | NTGT | Target currently holds a connection |
| conn_src_o | output | NTGT*SW | Owning source index per target, field t at bits t*SW +: SW |

## Verification
The hardest case to reach is a single source requesting several idle targets in the same cycle. That case exercises the one-grant rule, the precedence of outputs over shared buffers and the up-output rotation all at once. Random stimulus rarely produces it with a known rotation state, so directed phases set it up from a freshly reset state. In those phases one source requests a down output and a shared buffer together, and one source requests two up outputs twice in a row, with a release in between. A long random phase follows, with dense requests and frequent trailers. A behavioural model in the bench is compared on every clock throughout that phase.

// File: rtl/tree_out_alloc.sv
module tree_out_alloc #(
  parameter int N_SH   = 2,
  parameter int N_UP   = 4,
  parameter int N_LO   = 4,
  parameter int N_DOUT = 4,
  parameter int N_UOUT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [(N_SH+N_UP+N_LO)*(N_DOUT+N_UOUT+N_SH)-1:0] req_i,
  input  logic [N_SH+N_UP+N_LO-1:0]  trailer_i,
  output logic [N_DOUT+N_UOUT+N_SH-1:0] conn_valid_o,
  output logic [(N_DOUT+N_UOUT+N_SH)*$clog2(N_SH+N_UP+N_LO)-1:0] conn_src_o
);
  localparam int NSRC = N_SH + N_UP + N_LO;
  localparam int NTGT = N_DOUT + N_UOUT + N_SH;
  localparam int SW   = $clog2(NSRC);
  localparam int MAXC = (N_SH > N_UP) ? ((N_SH > N_LO) ? N_SH : N_LO) : ((N_UP > N_LO) ? N_UP : N_LO);
  localparam int PW   = $clog2(MAXC + 1);
  localparam int UW   = $clog2(N_UOUT + 1);

  function automatic int csize(input int c);
    return (c == 0) ? N_SH : (c == 1) ? N_UP : N_LO;
  endfunction

  function automatic int cbase(input int c);
    return (c == 0) ? 0 : (c == 1) ? N_SH : N_SH + N_UP;
  endfunction

  logic [NTGT-1:0] busy, nbusy;
  logic [SW-1:0]   owner [NTGT];
  logic [SW-1:0]   nowner [NTGT];
  logic [PW-1:0]   ptr [NTGT][3];
  logic [PW-1:0]   nptr [NTGT][3];
  logic [UW-1:0]   up_start, nup;
  logic [NSRC-1:0] src_busy;
  logic [NSRC-1:0] taken;

  always_comb begin
    src_busy = '0;
    for (int t = 0; t < NTGT; t++)
      if (busy[t]) src_busy[owner[t]] = 1'b1;
  end

  always_comb begin
    int t, s, pos;
    logic found, up_hit;
    taken  = src_busy;
    nbusy  = busy;
    nowner = owner;
    nptr   = ptr;
    nup    = up_start;
    up_hit = 1'b0;
    t = 0; s = 0; pos = 0; found = 1'b0;
    for (int o = 0; o < NTGT; o++) begin
      if (o >= N_DOUT && o < N_DOUT + N_UOUT)
        t = N_DOUT + ((int'(up_start) + o - N_DOUT) % N_UOUT);
      else
        t = o;
      found = 1'b0;
      if (!busy[t]) begin
        for (int c = 0; c < 3; c++) begin
          for (int k = 0; k < MAXC; k++) begin
            if (!found && k < csize(c)) begin
              pos = (int'(ptr[t][c]) + k) % csize(c);
              s = cbase(c) + pos;
              if (req_i[s*NTGT+t] && !taken[s]) begin
                found      = 1'b1;
                taken[s]   = 1'b1;
                nbusy[t]   = 1'b1;
                nowner[t]  = SW'(s);
                nptr[t][c] = PW'((pos + 1) % csize(c));
              end
            end
          end
        end
        if (found && !up_hit && t >= N_DOUT && t < N_DOUT + N_UOUT) begin
          up_hit = 1'b1;
          nup    = UW'((t - N_DOUT + 1) % N_UOUT);
        end
      end
    end
    for (int r = 0; r < NTGT; r++)
      if (busy[r] && trailer_i[owner[r]]) nbusy[r] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= '0;
      up_start <= '0;
      for (int t = 0; t < NTGT; t++) begin
        owner[t] <= '0;
        for (int c = 0; c < 3; c++) ptr[t][c] <= '0;
      end
    end else begin
      busy     <= nbusy;
      owner    <= nowner;
      ptr      <= nptr;
      up_start <= nup;
    end
  end

  assign conn_valid_o = busy;

  for (genvar g = 0; g < NTGT; g++) begin : g_out
    assign conn_src_o[g*SW +: SW] = owner[g];

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && !trailer_i[owner[g]]) |=> (busy[g] && $stable(owner[g])));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && trailer_i[owner[g]]) |=> !busy[g]);

    for (genvar h = 0; h < NSRC; h++) begin : g_src
      a_r10_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy[g] && req_i[h*NTGT+g] && !src_busy[h]) |=> (busy[g] || src_busy[h]));
    end
  end

  for (genvar h = 0; h < NSRC; h++) begin : g_own
    logic [NTGT-1:0] owns;
    for (genvar g = 0; g < NTGT; g++) begin : g_bit
      assign owns[g] = busy[g] && (owner[g] == SW'(h));
    end
    a_r3_single_conn: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(owns) <= 1);
  end
endmodule

// File: tb/tree_out_alloc_tb.sv
module tree_out_alloc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 10;
  localparam int NT = 10;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*NT-1:0] req = '0;
  logic [NS-1:0] trl = '0;
  logic [NT-1:0] cv;
  logic [NT*SW-1:0] cs;
  int checks = 0;
  int errors = 0;

  tree_out_alloc dut_i (.clk(clk), .rst_n(rst_n), .req_i(req), .trailer_i(trl),
                        .conn_valid_o(cv), .conn_src_o(cs));

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_busy[NT];
  int m_own[NT];
  int m_ptr[NT][3];
  int m_up;
  int free_s[NS];
  int rel[NT];
  int order[$];

  function automatic int class_lo(int c); return c == 0 ? 0 : c == 1 ? 2 : 6; endfunction
  function automatic int class_n(int c);  return c == 0 ? 2 : 4; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_up = 0;
      foreach (m_busy[t]) begin
        m_busy[t] = 0; m_own[t] = 0;
        for (int c = 0; c < 3; c++) m_ptr[t][c] = 0;
      end
    end else begin
      bit first_up;
      first_up = 1;
      foreach (free_s[s]) free_s[s] = 1;
      foreach (m_busy[t]) begin
        if (m_busy[t]) free_s[m_own[t]] = 0;
        rel[t] = m_busy[t] && trl[m_own[t]];
      end
      order.delete();
      for (int t = 0; t < 4; t++) order.push_back(t);
      for (int k = 0; k < 4; k++) order.push_back(4 + (m_up + k) % 4);
      order.push_back(8); order.push_back(9);
      foreach (order[i]) begin
        int t;
        bit done;
        t = order[i];
        done = 0;
        if (!m_busy[t]) begin
          for (int c = 0; c < 3 && !done; c++)
            for (int k = 0; k < class_n(c) && !done; k++) begin
              int p, s;
              p = (m_ptr[t][c] + k) % class_n(c);
              s = class_lo(c) + p;
              if (req[s*NT+t] && free_s[s]) begin
                done = 1; free_s[s] = 0;
                m_busy[t] = 1; m_own[t] = s;
                m_ptr[t][c] = (p + 1) % class_n(c);
              end
            end
          if (done && t >= 4 && t < 8 && first_up) begin
            first_up = 0;
            m_up = (t - 4 + 1) % 4;
          end
        end
      end
      foreach (rel[t]) if (rel[t]) m_busy[t] = 0;
    end
  end

  task automatic tick();
    @(negedge clk);
    checks++;
    for (int t = 0; t < NT; t++) begin
      if (cv[t] !== m_busy[t][0] || (m_busy[t] != 0 && cs[t*SW +: SW] !== SW'(m_own[t]))) begin
        errors++;
        $display("FAIL R2 R10 model mismatch target %0d: actual valid=%0b src=%0d expected valid=%0d src=%0d",
                 t, cv[t], cs[t*SW +: SW], m_busy[t], m_own[t]);
        break;
      end
    end
  endtask

  task automatic expect_conn(int t, bit v, int s, string tag);
    checks++;
    if (cv[t] !== v || (v && cs[t*SW +: SW] !== SW'(s))) begin
      errors++;
      $display("FAIL %s target %0d: actual valid=%0b src=%0d expected valid=%0b src=%0d",
               tag, t, cv[t], cs[t*SW +: SW], v, s);
    end
  endtask

  function automatic void r(int s, int t, bit v); req[s*NT+t] = v; endfunction

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int t = 0; t < NT; t++) expect_conn(t, 0, 0, "R9");
    rst_n = 1'b1;
    // R4: shared beats upper beats lower
    r(1,0,1); r(3,0,1); r(9,0,1);
    tick(); expect_conn(0, 1, 1, "R4");
    trl[1] = 1; r(1,0,0);
    tick(); expect_conn(0, 0, 0, "R8");
    trl = '0;
    tick(); expect_conn(0, 1, 3, "R4");
    trl[3] = 1; r(3,0,0);
    tick(); trl = '0;
    tick(); expect_conn(0, 1, 9, "R4");
    trl[9] = 1; req = '0;
    tick(); trl = '0;
    // R5: round-robin within upper class on target 1
    r(2,1,1); r(3,1,1);
    tick(); expect_conn(1, 1, 2, "R5");
    trl[2] = 1; tick(); trl = '0;
    tick(); expect_conn(1, 1, 3, "R5");
    trl[3] = 1; tick(); trl = '0;
    tick(); expect_conn(1, 1, 2, "R5");
    trl[2] = 1; req = '0; tick(); trl = '0;
    // R6 and R1: down output 2 beats shared buffer target 8
    r(6,2,1); r(6,8,1);
    tick(); expect_conn(2, 1, 6, "R6"); expect_conn(8, 0, 0, "R6");
    trl[6] = 1; req = '0; tick(); trl = '0;
    // R7: up outputs 4 and 5 compete for source 7
    r(7,4,1); r(7,5,1);
    tick(); expect_conn(4, 1, 7, "R7"); expect_conn(5, 0, 0, "R7");
    trl[7] = 1; tick(); trl = '0;
    tick(); expect_conn(5, 1, 7, "R7"); expect_conn(4, 0, 0, "R7");
    trl[7] = 1; req = '0; tick(); trl = '0;
    // R8: trailer of an unconnected source is ignored
    r(4,3,1);
    tick(); expect_conn(3, 1, 4, "R8");
    req = '0; trl[5] = 1;
    tick(); expect_conn(3, 1, 4, "R8");
    trl = '0; trl[4] = 1; tick(); trl = '0;
    // R3: requests of a connected source are ignored
    r(0,6,1);
    tick(); expect_conn(6, 1, 0, "R3");
    r(0,7,1);
    tick(); expect_conn(7, 0, 0, "R3"); expect_conn(6, 1, 0, "R3");
    trl[0] = 1; req = '0; tick(); trl = '0;
    tick();
    // random phase, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < NS*NT; b++) req[b] = ($urandom % 4) == 0;
      for (int s = 0; s < NS; s++) trl[s] = ($urandom % 3) == 0;
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule